// File: doc/BRIEF.md
# Synchronous Slave FIFO IN-Endpoint Emulator

This block stands in for the device side of a synchronous slave-FIFO bridge. An FPGA pushes bytes into it for bulk IN traffic toward a host. It runs on an interface clock supplied from outside, and a parameter range of 5 to 48 MHz is legal. A 2-bit address picks one of four endpoint buffers. A write strobe, gated by a chip select, stores one byte per clock into the selected endpoint. Each endpoint has two packet banks. A bank is committed to the host side as soon as it holds `AUTO_LEN` bytes, or earlier when the packet-end strobe is pulsed.

The selected endpoint reports a full flag and an empty flag on the pins. The polarity of every strobe and flag is set by a parameter. A simple host port lets the host pick an endpoint and pop committed packets one byte at a time. Zero-length packets are marked and take a single pop to remove.

A housekeeping path mirrors the usual bring-up order. First a global NAK-all is raised, which refuses all host reads. Then the endpoints are cleared one by one, and finally NAK-all is released. Writes aimed at a full endpoint are dropped and counted in a saturating overflow counter.

Top module: `slave_fifo_ep_emu`

## Requirements
- R1: With the chip select active and the write strobe active, the byte on `data_i` is stored in the endpoint chosen by `addr_i` (index 0..3, where 2'b10 is index 2), provided that endpoint holds fewer than two committed packets. The host later reads the bytes in write order.
- R2: When the bank being filled reaches `AUTO_LEN` bytes, it is committed with no further action, and `host_rdy_o` rises for that endpoint on the following cycle.
- R3: A write to an endpoint with two committed packets is dropped, and the stored data stays unchanged. Each such write raises `ovf_cnt_o` by one, and the count saturates at 2^OVF_W-1.
- R4: The full flag of the selected endpoint is active exactly when two committed packets are pending. An endpoint therefore accepts 2*AUTO_LEN bytes before it reports full.
- R5: A packet-end strobe, with the chip select active and the endpoint not full, commits the partial bank at once. If the partial bank is empty, it commits a zero-length packet, which the host sees through `host_zlp_o`.
- R6: While the chip select is inactive (`cs_i` high), both the write strobe and the packet-end strobe have no effect.
- R7: With the default parameters, the chip select is active-low, the write strobe is active-high, packet-end is active-low, and both the full and empty flags are active-low.
- R8: The empty flag is active when the selected endpoint holds no committed packet (a zero-length one counts as committed) and no partial bytes. Both flags show the new state in the cycle after the clock edge that accepted the write, commit or pop.
- R9: Each `host_pop_i` removes one byte from the head packet of `host_sel_i`. `host_last_o` marks the final byte of that packet. A zero-length packet is removed by a single pop.
- R10: While `nak_all_i` is high, `host_rdy_o` stays low and host pops are ignored.
- R11: `ep_rst_i` clears the endpoint chosen by `ep_rst_sel_i` only while `nak_all_i` is high. Other endpoints keep their state, and outside NAK-all the strobe has no effect.
- R12: After reset, every endpoint is empty and not full, `host_rdy_o` is low and `ovf_cnt_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Slave chip select pin |
| wr_i | input | 1 | Write strobe pin |
| pktend_i | input | 1 | Packet-end strobe pin |
| addr_i | input | ADDR_W | Endpoint select |
| data_i | input | DATA_W | Write data |
| full_o | output | 1 | Full flag pin of the selected endpoint |
| empty_o | output | 1 | Empty flag pin of the selected endpoint |
| nak_all_i | input | 1 | Refuse host reads, enable endpoint clears |
| ep_rst_i | input | 1 | Endpoint clear strobe |
| ep_rst_sel_i | input | ADDR_W | Endpoint to clear |
| host_sel_i | input | ADDR_W | Endpoint the host reads |
| host_pop_i | input | 1 | Pop one byte or one zero-length packet |
| host_rdy_o | output | 1 | Committed packet available and reads allowed |
| host_data_o | output | DATA_W | Head byte of the host endpoint |
| host_last_o | output | 1 | Head byte is the last of its packet |
| host_zlp_o | output | 1 | Head packet has zero length |
| ovf_cnt_o | output | OVF_W | Saturating count of dropped writes |

## Verification
The bench builds the block with `AUTO_LEN` = 8, `OVF_W` = 4 and the default polarities. With these values, auto-commit, the full flag after two banks, and counter saturation at 15 all occur within a few dozen writes. This lets the random traffic across all four endpoints cross these boundaries many times. Directed sequences cover zero-length and short packets, the ignored strobes, and the NAK-all clear order.

// File: rtl/slave_fifo_pkg.sv
package slave_fifo_pkg;

  typedef struct packed {
    logic full;
    logic empty;
    logic avail;
    logic last;
    logic zlp;
  } ep_stat_t;

  // maps between internal active-high level and pin level
  function automatic logic pin_map(logic lvl, bit act_hi);
    return act_hi ? lvl : ~lvl;
  endfunction

endpackage

// File: rtl/slave_fifo_pins.sv
module slave_fifo_pins
  import slave_fifo_pkg::*;
#(
  parameter bit CS_HI     = 1'b0,
  parameter bit WR_HI     = 1'b1,
  parameter bit PKTEND_HI = 1'b0,
  parameter bit FULL_HI   = 1'b0,
  parameter bit EMPTY_HI  = 1'b0
) (
  input  logic cs_pin_i,
  input  logic wr_pin_i,
  input  logic pe_pin_i,
  input  logic full_i,
  input  logic empty_i,
  output logic cs_o,
  output logic wr_o,
  output logic pe_o,
  output logic full_pin_o,
  output logic empty_pin_o
);

  assign cs_o        = pin_map(cs_pin_i, CS_HI);
  assign wr_o        = pin_map(wr_pin_i, WR_HI);
  assign pe_o        = pin_map(pe_pin_i, PKTEND_HI);
  assign full_pin_o  = pin_map(full_i, FULL_HI);
  assign empty_pin_o = pin_map(empty_i, EMPTY_HI);

endmodule

// File: rtl/slave_fifo_ovf.sv
module slave_fifo_ovf #(
  parameter int OVF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [OVF_W-1:0] cnt_o
);

  localparam logic [OVF_W-1:0] MAX = {OVF_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/slave_fifo_ep.sv
module slave_fifo_ep
  import slave_fifo_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int AUTO_LEN = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              pe_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output ep_stat_t          stat_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drop_o
);

  localparam int DEPTH = 2 * AUTO_LEN;
  localparam int CW    = $clog2(AUTO_LEN + 1);
  localparam int MW    = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_bank, rd_bank;
  logic [CW-1:0]     cnt, rd_off;
  logic [CW-1:0]     len_q [2];
  logic [1:0]        pend;

  logic          full, wr_ok, pe_ok, commit, pop_ok, pop_done;
  logic [CW-1:0] cnt_nxt, head_len;
  logic [MW-1:0] wr_idx, rd_idx;

  assign full     = (pend == 2'd2);
  assign wr_ok    = wr_i & ~full;
  assign pe_ok    = pe_i & ~full;
  assign cnt_nxt  = cnt + CW'(wr_ok);
  assign commit   = pe_ok | (wr_ok && cnt_nxt == CW'(AUTO_LEN));
  assign head_len = len_q[rd_bank];
  assign pop_ok   = pop_i & (pend != 2'd0);
  assign pop_done = pop_ok & ((head_len == '0) || (rd_off + CW'(1) == head_len));
  assign wr_idx   = MW'(int'(wr_bank) * AUTO_LEN + int'(cnt));
  assign rd_idx   = MW'(int'(rd_bank) * AUTO_LEN + int'(rd_off));

  // data store, no reset needed
  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wr_idx] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bank  <= 1'b0;
      rd_bank  <= 1'b0;
      cnt      <= '0;
      rd_off   <= '0;
      pend     <= '0;
      len_q[0] <= '0;
      len_q[1] <= '0;
    end else if (flush_i) begin
      wr_bank  <= 1'b0;
      rd_bank  <= 1'b0;
      cnt      <= '0;
      rd_off   <= '0;
      pend     <= '0;
      len_q[0] <= '0;
      len_q[1] <= '0;
    end else begin
      if (commit) begin
        len_q[wr_bank] <= cnt_nxt;
        cnt            <= '0;
        wr_bank        <= ~wr_bank;
      end else if (wr_ok) begin
        cnt <= cnt_nxt;
      end
      if (pop_done) begin
        rd_off  <= '0;
        rd_bank <= ~rd_bank;
      end else if (pop_ok) begin
        rd_off <= rd_off + CW'(1);
      end
      pend <= pend + {1'b0, commit} - {1'b0, pop_done};
    end
  end

  assign stat_o.full  = full;
  assign stat_o.empty = (pend == 2'd0) && (cnt == '0);
  assign stat_o.avail = (pend != 2'd0);
  assign stat_o.last  = (pend != 2'd0) && (head_len != '0) && (rd_off + CW'(1) == head_len);
  assign stat_o.zlp   = (pend != 2'd0) && (head_len == '0);
  assign rdata_o      = mem[rd_idx];
  assign drop_o       = wr_i & full;

endmodule

// File: rtl/slave_fifo_ep_emu.sv
module slave_fifo_ep_emu
  import slave_fifo_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int AUTO_LEN  = 512,
  parameter int OVF_W     = 8,
  parameter bit CS_HI     = 1'b0,
  parameter bit WR_HI     = 1'b1,
  parameter bit PKTEND_HI = 1'b0,
  parameter bit FULL_HI   = 1'b0,
  parameter bit EMPTY_HI  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              pktend_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              full_o,
  output logic              empty_o,
  input  logic              nak_all_i,
  input  logic              ep_rst_i,
  input  logic [ADDR_W-1:0] ep_rst_sel_i,
  input  logic [ADDR_W-1:0] host_sel_i,
  input  logic              host_pop_i,
  output logic              host_rdy_o,
  output logic [DATA_W-1:0] host_data_o,
  output logic              host_last_o,
  output logic              host_zlp_o,
  output logic [OVF_W-1:0]  ovf_cnt_o
);

  localparam int NUM_EP = 1 << ADDR_W;

  logic cs_act, wr_act, pe_act;
  ep_stat_t          stat  [NUM_EP];
  logic [DATA_W-1:0] rdata [NUM_EP];
  logic [NUM_EP-1:0] drop;
  ep_stat_t          wsel, hsel;

  assign wsel = stat[addr_i];
  assign hsel = stat[host_sel_i];

  slave_fifo_pins #(
    .CS_HI(CS_HI), .WR_HI(WR_HI), .PKTEND_HI(PKTEND_HI),
    .FULL_HI(FULL_HI), .EMPTY_HI(EMPTY_HI)
  ) u_pins (
    .cs_pin_i    (cs_i),
    .wr_pin_i    (wr_i),
    .pe_pin_i    (pktend_i),
    .full_i      (wsel.full),
    .empty_i     (wsel.empty),
    .cs_o        (cs_act),
    .wr_o        (wr_act),
    .pe_o        (pe_act),
    .full_pin_o  (full_o),
    .empty_pin_o (empty_o)
  );

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic hit, hpick, rpick;
    assign hit   = cs_act && (addr_i == ADDR_W'(e));
    assign hpick = host_pop_i && !nak_all_i && (host_sel_i == ADDR_W'(e));
    assign rpick = ep_rst_i && nak_all_i && (ep_rst_sel_i == ADDR_W'(e));

    slave_fifo_ep #(
      .DATA_W(DATA_W), .AUTO_LEN(AUTO_LEN)
    ) u_ep (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (hit & wr_act),
      .pe_i    (hit & pe_act),
      .data_i  (data_i),
      .pop_i   (hpick),
      .flush_i (rpick),
      .stat_o  (stat[e]),
      .rdata_o (rdata[e]),
      .drop_o  (drop[e])
    );
  end

  slave_fifo_ovf #(.OVF_W(OVF_W)) u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (|drop),
    .cnt_o  (ovf_cnt_o)
  );

  assign host_rdy_o  = hsel.avail & ~nak_all_i;
  assign host_data_o = rdata[host_sel_i];
  assign host_last_o = hsel.last;
  assign host_zlp_o  = hsel.zlp;

endmodule

// File: rtl/slave_fifo_chk.sv
module slave_fifo_chk #(
  parameter int ADDR_W   = 2,
  parameter int OVF_W    = 8,
  parameter bit CS_HI    = 1'b0,
  parameter bit FULL_HI  = 1'b0,
  parameter bit EMPTY_HI = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              full_o,
  input logic              empty_o,
  input logic              nak_all_i,
  input logic              ep_rst_i,
  input logic              host_pop_i,
  input logic              host_rdy_o,
  input logic              host_last_o,
  input logic              host_zlp_o,
  input logic [OVF_W-1:0]  ovf_cnt_o
);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_cnt_o >= $past(ovf_cnt_o)) && (ovf_cnt_o - $past(ovf_cnt_o) <= OVF_W'(1)));

  assert_nak_refuse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nak_all_i |-> !host_rdy_o);

  assert_full_not_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o == FULL_HI) |-> (empty_o != EMPTY_HI));

  assert_cs_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i != CS_HI && !host_pop_i && !ep_rst_i) |=>
      (!$stable(addr_i) || ($stable(full_o) && $stable(empty_o))));

  assert_zlp_not_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_zlp_o |-> !host_last_o);

endmodule

bind slave_fifo_ep_emu slave_fifo_chk #(
  .ADDR_W(ADDR_W), .OVF_W(OVF_W), .CS_HI(CS_HI),
  .FULL_HI(FULL_HI), .EMPTY_HI(EMPTY_HI)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_i        (cs_i),
  .addr_i      (addr_i),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .nak_all_i   (nak_all_i),
  .ep_rst_i    (ep_rst_i),
  .host_pop_i  (host_pop_i),
  .host_rdy_o  (host_rdy_o),
  .host_last_o (host_last_o),
  .host_zlp_o  (host_zlp_o),
  .ovf_cnt_o   (ovf_cnt_o)
);

// File: tb/slave_fifo_ep_emu_tb.sv
module slave_fifo_ep_emu_tb;

  localparam int PER      = 10;
  localparam int AUTO_LEN = 8;
  localparam int ADDR_W   = 2;
  localparam int NEP      = 4;
  localparam int OVF_W    = 4;
  localparam int OVF_MAX  = 15;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_i = 1'b1, wr_i = 1'b0, pktend_i = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0, ep_rst_sel_i = '0, host_sel_i = '0;
  logic [7:0] data_i = '0;
  logic nak_all_i = 1'b0, ep_rst_i = 1'b0, host_pop_i = 1'b0;
  logic full_o, empty_o, host_rdy_o, host_last_o, host_zlp_o;
  logic [7:0] host_data_o;
  logic [OVF_W-1:0] ovf_cnt_o;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] part_q [NEP][$];
  logic [7:0] pkt_q  [NEP][$];
  int         len_q  [NEP][$];
  int         hoff   [NEP];
  int         ovf_m = 0;

  always #(PER/2) clk = ~clk;

  slave_fifo_ep_emu #(
    .DATA_W(8), .ADDR_W(ADDR_W), .AUTO_LEN(AUTO_LEN), .OVF_W(OVF_W)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs_i), .wr_i(wr_i), .pktend_i(pktend_i),
    .addr_i(addr_i), .data_i(data_i), .full_o(full_o), .empty_o(empty_o),
    .nak_all_i(nak_all_i), .ep_rst_i(ep_rst_i), .ep_rst_sel_i(ep_rst_sel_i),
    .host_sel_i(host_sel_i), .host_pop_i(host_pop_i), .host_rdy_o(host_rdy_o),
    .host_data_o(host_data_o), .host_last_o(host_last_o), .host_zlp_o(host_zlp_o),
    .ovf_cnt_o(ovf_cnt_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int pend(int e);
    return len_q[e].size();
  endfunction

  task automatic commit(int e);
    foreach (part_q[e][i]) pkt_q[e].push_back(part_q[e][i]);
    len_q[e].push_back(part_q[e].size());
    part_q[e].delete();
  endtask

  // reference model: one clock edge
  task automatic model_step();
    int a = int'(addr_i);
    int h = int'(host_sel_i);
    int pa = pend(a);
    int ph = pend(h);
    bit cs_act = (cs_i == 1'b0);
    if (nak_all_i && ep_rst_i) begin
      int r = int'(ep_rst_sel_i);
      part_q[r].delete(); pkt_q[r].delete(); len_q[r].delete(); hoff[r] = 0;
      return;
    end
    if (cs_act && wr_i) begin
      if (pa == 2) begin
        if (ovf_m < OVF_MAX) ovf_m++;
      end else part_q[a].push_back(data_i);
    end
    if (cs_act && pa < 2 && (pktend_i == 1'b0 || part_q[a].size() == AUTO_LEN)) commit(a);
    if (host_pop_i && !nak_all_i && ph > 0) begin
      if (len_q[h][0] == 0) void'(len_q[h].pop_front());
      else begin
        void'(pkt_q[h].pop_front());
        hoff[h]++;
        if (hoff[h] == len_q[h][0]) begin
          void'(len_q[h].pop_front());
          hoff[h] = 0;
        end
      end
    end
  endtask

  task automatic compare();
    int a = int'(addr_i);
    int h = int'(host_sel_i);
    bit av = pend(h) > 0;
    chk("R4 full", int'(full_o), (pend(a) == 2) ? 0 : 1);
    chk("R8 empty", int'(empty_o), (pend(a) == 0 && part_q[a].size() == 0) ? 0 : 1);
    chk("R10 rdy", int'(host_rdy_o), (av && !nak_all_i) ? 1 : 0);
    chk("R5 zlp", int'(host_zlp_o), (av && len_q[h][0] == 0) ? 1 : 0);
    chk("R9 last", int'(host_last_o), (av && len_q[h][0] != 0 && len_q[h][0] - hoff[h] == 1) ? 1 : 0);
    if (av && len_q[h][0] != 0) chk("R1 data", int'(host_data_o), int'(pkt_q[h][0]));
    chk("R3 ovf", int'(ovf_cnt_o), ovf_m);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #(PER/4);
    compare();
    @(negedge clk);
  endtask

  task automatic idle();
    cs_i = 1'b1; wr_i = 1'b0; pktend_i = 1'b1;
    host_pop_i = 1'b0; ep_rst_i = 1'b0;
  endtask

  task automatic wr_byte(int a, int d);
    cs_i = 1'b0; wr_i = 1'b1; addr_i = ADDR_W'(a); data_i = 8'(d);
    tick(); idle();
  endtask

  task automatic pkt_end(int a);
    cs_i = 1'b0; pktend_i = 1'b0; addr_i = ADDR_W'(a);
    tick(); idle();
  endtask

  task automatic pop(int h);
    host_sel_i = ADDR_W'(h); host_pop_i = 1'b1;
    tick(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int e = 0; e < NEP; e++) hoff[e] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R12 reset state
    chk("R12 full", int'(full_o), 1);
    chk("R12 empty", int'(empty_o), 0);
    chk("R12 rdy", int'(host_rdy_o), 0);
    chk("R12 ovf", int'(ovf_cnt_o), 0);
    @(negedge clk);

    // R1 R2 R8: fill one bank of endpoint index 2 (addr 2'b10)
    host_sel_i = 2'd2;
    wr_byte(2, 8'h10);
    chk("R8 not empty after one byte", int'(empty_o), 1);
    chk("R2 no commit yet", int'(host_rdy_o), 0);
    for (int i = 1; i < AUTO_LEN; i++) wr_byte(2, 8'h10 + i);
    chk("R2 auto commit", int'(host_rdy_o), 1);
    chk("R1 first byte", int'(host_data_o), 8'h10);
    chk("R4 one bank not full", int'(full_o), 1);

    // R4 second bank, R3 overflow and saturation
    for (int i = 0; i < AUTO_LEN; i++) wr_byte(2, 8'h20 + i);
    chk("R4 full after two banks", int'(full_o), 0);
    wr_byte(2, 8'hEE);
    chk("R3 one drop", int'(ovf_cnt_o), 1);
    for (int i = 0; i < 20; i++) wr_byte(2, 8'hEE);
    chk("R3 saturated", int'(ovf_cnt_o), OVF_MAX);
    chk("R3 data kept", int'(host_data_o), 8'h10);

    // R6 chip select inactive, R7 inactive write level
    host_sel_i = 2'd1;
    cs_i = 1'b1; wr_i = 1'b1; addr_i = 2'd1; data_i = 8'h55; tick(); idle();
    chk("R6 write ignored", int'(empty_o), 0);
    cs_i = 1'b1; pktend_i = 1'b0; addr_i = 2'd1; tick(); idle();
    chk("R6 pktend ignored", int'(host_rdy_o), 0);
    cs_i = 1'b0; wr_i = 1'b0; addr_i = 2'd1; data_i = 8'h66; tick(); idle();
    chk("R7 low write level stores nothing", int'(empty_o), 0);

    // R5 zero-length packet
    pkt_end(1);
    chk("R5 zlp committed", int'(host_zlp_o), 1);
    chk("R5 zlp ready", int'(host_rdy_o), 1);
    pop(1);
    chk("R9 zlp removed by one pop", int'(host_rdy_o), 0);

    // R5 short packet, R9 order and last marker
    host_sel_i = 2'd3;
    wr_byte(3, 8'hA1); wr_byte(3, 8'hA2); wr_byte(3, 8'hA3);
    chk("R5 partial not ready", int'(host_rdy_o), 0);
    pkt_end(3);
    chk("R5 short packet ready", int'(host_rdy_o), 1);
    chk("R9 head byte", int'(host_data_o), 8'hA1);
    pop(3); pop(3);
    chk("R9 last marked", int'(host_last_o), 1);
    chk("R9 third byte", int'(host_data_o), 8'hA3);
    pop(3);
    chk("R9 packet drained", int'(host_rdy_o), 0);

    // R10 NAK-all refuses reads
    host_sel_i = 2'd2;
    nak_all_i = 1'b1; tick();
    chk("R10 rdy low", int'(host_rdy_o), 0);
    pop(2);
    nak_all_i = 1'b0; tick();
    chk("R10 pop ignored", int'(host_data_o), 8'h10);

    // R11 clear only under NAK-all
    addr_i = 2'd2; ep_rst_sel_i = 2'd2; ep_rst_i = 1'b1; tick(); idle();
    chk("R11 clear ignored outside nak", int'(full_o), 0);
    wr_byte(0, 8'h01);
    nak_all_i = 1'b1; tick();
    for (int e = 0; e < NEP; e++) begin
      ep_rst_sel_i = ADDR_W'(e); ep_rst_i = 1'b1; tick(); idle();
    end
    nak_all_i = 1'b0; tick();
    for (int e = 0; e < NEP; e++) begin
      addr_i = ADDR_W'(e); tick();
      chk("R11 endpoint cleared", int'(empty_o), 0);
    end
    chk("R11 counter kept", int'(ovf_cnt_o), OVF_MAX);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      addr_i     = ADDR_W'($urandom % NEP);
      data_i     = 8'($urandom);
      cs_i       = ($urandom % 8 == 0);
      wr_i       = ($urandom % 4 != 0);
      pktend_i   = !($urandom % 16 == 0);
      host_sel_i = ADDR_W'($urandom % NEP);
      host_pop_i = ($urandom % 2 == 0);
      nak_all_i  = ($urandom % 20 == 0);
      tick();
    end
    idle(); nak_all_i = 1'b0; tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule